// File: doc/BRIEF.md
# Instruction-Driven Pulse Sequencer

This block is a small timing processor. It fetches instruction words from an on-chip program memory and drives a 24-bit flag word. The flag word stays constant for a programmed number of clock cycles per instruction. The flags carry internal control lines, such as frequency select, phase select, output enable and phase reset, together with general-purpose outputs. Only the output-enable line has meaning inside the block.

The sequencer supports:
- counted loops, which can be nested;
- subroutine calls and returns;
- unconditional jumps;
- multiplied long delays;
- a pause that lasts until a trigger arrives.

A host fills the program memory through a simple write port while the sequencer is idle. The host then starts the program with a software trigger pulse or by pulling the active-low hardware trigger low. Once started, the sequencer runs on its own until a STOP instruction or a stack fault.

Loop counts and return addresses are kept on two small stacks. A stack overflow or underflow halts the sequencer with the enable line forced off. It also raises a sticky error that only reset clears.

Top module: `pulse_seq`

## Requirements
- R1: An instruction word is 64 bits. The flags are in [63:40], the opcode in [39:36], the data field in [35:16] and the delay in [15:0]. The opcodes are 0 CONTINUE, 1 STOP, 2 LOOP, 3 END_LOOP, 4 JSR, 5 RTS, 6 BRANCH, 7 LONG_DELAY and 8 WAIT. Unused codes act as CONTINUE.
- R2: An instruction other than STOP, WAIT and LONG_DELAY presents its flags for max(delay, 5) cycles. The flags do not change during that time. Execution then moves to the next address unless the opcode redirects it.
- R3: After a synchronous active-low reset, the flags are 0, `running` is 0, `seq_error` is 0 and the program counter is 0.
- R4: While idle, a trigger starts execution at the current program counter. A trigger is `sw_trig` high or `hw_trig_n` low, sampled at a clock edge. The first instruction's flags appear right after that edge. Triggers sampled while an instruction runs have no effect.
- R5: LOOP pushes its data value as a count, with 0 treated as 1. When END_LOOP finishes with a top count above 1, it decrements the count and jumps to the address in its data field. Otherwise it pops the count and continues. Loops may nest.
- R6: LONG_DELAY lasts max(delay, 5) × max(data, 2) cycles.
- R7: JSR pushes its own address plus one and jumps to its data field. RTS pops that address and continues there. Calls may nest.
- R8: BRANCH jumps unconditionally to the address in its data field.
- R9: WAIT presents its flags and pauses until a trigger is sampled. After that edge, the flags stay for max(delay, 5) + 6 more cycles before the next instruction's flags appear.
- R10: Fetching STOP makes the sequencer idle at once with `running` low. STOP's flags are shown with bit 8 (the output enable) cleared. The program counter goes back to 0 and both stacks are emptied, so the next trigger restarts the program from address 0.
- R11: The loop-count and return-address stacks are each 8 entries deep. If an instruction would push to a full stack or use an empty one, the sequencer does the following when that instruction ends:
  - it halts and raises `seq_error`;
  - it clears bit 8 of the flags, which otherwise keep their value;
  - it ignores triggers until reset.
- R12: A program-memory write takes effect at the clock edge. A fetch of the same address at that same edge gets the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_trig | input | 1 | Software trigger, active high |
| hw_trig_n | input | 1 | Hardware trigger, active low, already synchronous to clk |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 10 | Program memory write address |
| prog_wdata | input | 64 | Instruction word to write |
| flags | output | 24 | Flag word of the current instruction |
| running | output | 1 | High while executing or paused in WAIT |
| seq_error | output | 1 | Sticky stack fault indicator |

## Verification
A host write to the program memory can land in the same cycle as the sequencer fetching that address. The bench counts cycles from the start trigger so that the write strobe lands exactly on the edge that loads the next instruction. It then requires the old word to appear, and the new word to appear on the following run. A trigger can also coincide with a running instruction's middle cycle. The bench pulses the software trigger inside a CONTINUE that comes before a WAIT. It judges that the CONTINUE keeps its full length and that WAIT still needs its own trigger.

// File: rtl/pseq_pkg.sv
// Shared widths, opcodes, instruction layout and sequencer states.
// Assumes a fixed 64-bit instruction word; the field order is part of the
// host-visible program format.
package pseq_pkg;
    localparam int FLAG_W = 24;
    localparam int OP_W   = 4;
    localparam int DATA_W = 20;
    localparam int DLY_W  = 16;
    localparam int WORD_W = FLAG_W + OP_W + DATA_W + DLY_W;

    typedef enum logic [OP_W-1:0] {
        OP_CONT    = 4'd0,
        OP_STOP    = 4'd1,
        OP_LOOP    = 4'd2,
        OP_ENDLOOP = 4'd3,
        OP_JSR     = 4'd4,
        OP_RTS     = 4'd5,
        OP_BRANCH  = 4'd6,
        OP_LDELAY  = 4'd7,
        OP_WAIT    = 4'd8
    } op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] data;
        logic [DLY_W-1:0]  dly;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_HALT
    } state_e;
endpackage

// File: rtl/pseq_prog_mem.sv
// Program memory: one synchronous write port for the host, one asynchronous
// read port for instruction fetch. A same-edge read returns the old word.
// Assumes no reset of contents; the host writes every word it executes.
module pseq_prog_mem #(
    parameter  int DEPTH = 1024,
    parameter  int W     = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // Host write into the instruction array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pseq_stack.sv
// LIFO used for loop counts and return addresses. It supports push, pop,
// rewrite of the top entry, and clear. The caller must not push when full or
// pop/rewrite when empty; it detects those cases itself.
module pseq_stack #(
    parameter  int DEPTH = 8,
    parameter  int W     = 20,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic         wr_top,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  slot_q [DEPTH];
    logic [CW-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign top   = slot_q[IW'(cnt_q - 1'b1)];

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Entry storage: push writes above the top, rewrite replaces the top.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            slot_q[IW'(cnt_q)] <= din;
        end else if (wr_top && !empty) begin
            slot_q[IW'(cnt_q - 1'b1)] <= din;
        end
    end

    AST_STK_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R11
    AST_STK_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || wr_top) |-> !empty); // R11
endmodule

// File: rtl/pulse_seq.sv
// Instruction-driven pulse sequencer. It fetches words from program memory
// and holds each word's flags for its length. It handles loops, calls,
// jumps, long delays and trigger waits. Assumes hw_trig_n is already
// synchronous to clk and that the host writes the program while idle.
module pulse_seq
    import pseq_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int STACK_DEPTH = 8,
    parameter int MIN_LEN     = 5,
    parameter int WAIT_EXTRA  = 6,
    parameter int EN_BIT      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_trig,
    input  logic              hw_trig_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_wdata,
    output logic [FLAG_W-1:0] flags,
    output logic              running,
    output logic              seq_error
);
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int CNT_W     = DLY_W + DATA_W;
    localparam logic [FLAG_W-1:0] EN_MASK = FLAG_W'(1) << EN_BIT;

    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OP_W-1:0]   cur_op_q;
    logic [DATA_W-1:0] cur_data_q;
    logic [DLY_W-1:0]  cur_dly_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FLAG_W-1:0] flags_q;
    logic              err_q;

    logic              trig;
    logic              end_ok;
    logic              fault;
    logic              ld;
    logic              stop_ld;
    logic [ADDR_W-1:0] nxt_pc;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    instr_t            fi;

    logic              lp_push, lp_pop, lp_wr, lp_empty, lp_full;
    logic [DATA_W-1:0] lp_din, lp_top;
    logic              rs_push, rs_pop, rs_empty, rs_full;
    logic [ADDR_W-1:0] rs_top;

    // Delay with the minimum instruction length applied.
    function automatic logic [CNT_W-1:0] eff_dly(input logic [DLY_W-1:0] d);
        return (d < DLY_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) : CNT_W'(d);
    endfunction

    // Cycle count of a fetched instruction (WAIT/STOP handled elsewhere).
    function automatic logic [CNT_W-1:0] run_len(input logic [OP_W-1:0] op,
                                                 input logic [DATA_W-1:0] n,
                                                 input logic [DLY_W-1:0] d);
        logic [CNT_W-1:0] mult;
        mult = (n < DATA_W'(2)) ? CNT_W'(2) : CNT_W'(n);
        return (op_e'(op) == OP_LDELAY) ? eff_dly(d) * mult : eff_dly(d);
    endfunction

    assign trig    = sw_trig || !hw_trig_n;
    assign end_ok  = (state_q == ST_RUN) && (cnt_q == '0);
    assign rd_addr = (state_q == ST_IDLE) ? pc_q : nxt_pc;
    assign fi      = instr_t'(rd_word);
    assign ld      = ((state_q == ST_IDLE) && trig) || (end_ok && !fault);
    assign stop_ld = ld && (op_e'(fi.op) == OP_STOP);

    pseq_prog_mem #(.DEPTH(MEM_DEPTH), .W(WORD_W)) mem_i (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_wdata),
        .raddr(rd_addr), .rdata(rd_word)
    );

    pseq_stack #(.DEPTH(STACK_DEPTH), .W(DATA_W)) loop_stk_i (
        .clk(clk), .rst_n(rst_n), .clr(stop_ld), .push(lp_push), .pop(lp_pop),
        .wr_top(lp_wr), .din(lp_din), .top(lp_top), .empty(lp_empty), .full(lp_full)
    );

    pseq_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) ret_stk_i (
        .clk(clk), .rst_n(rst_n), .clr(stop_ld), .push(rs_push), .pop(rs_pop),
        .wr_top(1'b0), .din(pc_q + ADDR_W'(1)), .top(rs_top), .empty(rs_empty),
        .full(rs_full)
    );

    // Flow control at the last cycle of an instruction: next address, stack ops, faults.
    always_comb begin
        nxt_pc  = pc_q + ADDR_W'(1);
        lp_push = 1'b0;
        lp_pop  = 1'b0;
        lp_wr   = 1'b0;
        lp_din  = cur_data_q;
        rs_push = 1'b0;
        rs_pop  = 1'b0;
        fault   = 1'b0;
        if (end_ok) begin
            case (op_e'(cur_op_q))
                OP_LOOP: begin
                    if (lp_full) fault = 1'b1;
                    else         lp_push = 1'b1;
                end
                OP_ENDLOOP: begin
                    if (lp_empty) begin
                        fault = 1'b1;
                    end else if (lp_top > DATA_W'(1)) begin
                        lp_wr  = 1'b1;
                        lp_din = lp_top - DATA_W'(1);
                        nxt_pc = cur_data_q[ADDR_W-1:0];
                    end else begin
                        lp_pop = 1'b1;
                    end
                end
                OP_JSR: begin
                    if (rs_full) begin
                        fault = 1'b1;
                    end else begin
                        rs_push = 1'b1;
                        nxt_pc  = cur_data_q[ADDR_W-1:0];
                    end
                end
                OP_RTS: begin
                    if (rs_empty) begin
                        fault = 1'b1;
                    end else begin
                        rs_pop = 1'b1;
                        nxt_pc = rs_top;
                    end
                end
                OP_BRANCH: nxt_pc = cur_data_q[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // Sequencer state, current instruction, cycle counter, flags and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pc_q       <= '0;
            cur_op_q   <= '0;
            cur_data_q <= '0;
            cur_dly_q  <= '0;
            cnt_q      <= '0;
            flags_q    <= '0;
            err_q      <= 1'b0;
        end else if (ld) begin
            cur_op_q   <= fi.op;
            cur_data_q <= fi.data;
            cur_dly_q  <= fi.dly;
            if (op_e'(fi.op) == OP_STOP) begin
                state_q <= ST_IDLE;
                pc_q    <= '0;
                flags_q <= fi.flags & ~EN_MASK;
            end else begin
                pc_q    <= rd_addr;
                flags_q <= fi.flags;
                if (op_e'(fi.op) == OP_WAIT) begin
                    state_q <= ST_WAIT;
                end else begin
                    state_q <= ST_RUN;
                    cnt_q   <= run_len(fi.op, fi.data, fi.dly) - CNT_W'(1);
                end
            end
        end else if ((state_q == ST_RUN) && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (state_q == ST_RUN) begin
            state_q <= ST_HALT;
            err_q   <= 1'b1;
            flags_q <= flags_q & ~EN_MASK;
        end else if ((state_q == ST_WAIT) && trig) begin
            state_q <= ST_RUN;
            cnt_q   <= eff_dly(cur_dly_q) + CNT_W'(WAIT_EXTRA) - CNT_W'(1);
        end
    end

    assign flags     = flags_q;
    assign running   = (state_q == ST_RUN) || (state_q == ST_WAIT);
    assign seq_error = err_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && (cnt_q != '0)) |=> $stable(flags)); // R2
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && !trig) |=> ((state_q == ST_WAIT) && $stable(flags))); // R9
    AST_IDLE_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !flags[EN_BIT]); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> (seq_error && !running)); // R11
    AST_ERR_RISE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_error) |-> ($past(running) && !running)); // R11
endmodule

// File: tb/pulse_seq_tb_top.sv
// Self-checking bench: sweeps delays, loop counts, long-delay multipliers,
// wait latencies and stack faults, and computes the expected run lengths.
module pulse_seq_tb_top;
    localparam logic [3:0] C_CONT = 4'd0, C_STOP = 4'd1, C_LOOP = 4'd2,
                           C_ENDL = 4'd3, C_JSR = 4'd4, C_RTS = 4'd5,
                           C_BR = 4'd6, C_LDLY = 4'd7, C_WAIT = 4'd8;
    localparam logic [23:0] ENM = 24'h000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_trig = 1'b0;
    logic        hw_trig_n = 1'b1;
    logic        prog_we = 1'b0;
    logic [9:0]  prog_addr = '0;
    logic [63:0] prog_wdata = '0;
    logic [23:0] flags;
    logic        running;
    logic        seq_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .hw_trig_n(hw_trig_n),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .flags(flags), .running(running), .seq_error(seq_error)
    );

    function automatic logic [63:0] ins(input logic [23:0] f, input logic [3:0] op,
                                        input logic [19:0] d, input logic [15:0] dl);
        return {f, op, d, dl};
    endfunction

    function automatic int eff(input int d);
        return (d < 5) ? 5 : d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [63:0] w);
        prog_we = 1'b1;
        prog_addr = 10'(a);
        prog_wdata = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic go();
        hw_trig_n = 1'b0;
        @(negedge clk);
        hw_trig_n = 1'b1;
    endtask

    // Flags must equal exp for len consecutive cycles.
    task automatic hold(input string tag, input logic [23:0] exp, input int len);
        logic [23:0] bad = '0;
        bit ok = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (ok && (flags !== exp || running !== 1'b1)) begin
                ok = 1'b0;
                bad = flags;
            end
            @(negedge clk);
        end
        check(tag, ok ? 32'(exp) : 32'(bad), 32'(exp));
    endtask

    task automatic stopped(input string tag, input logic [23:0] exp);
        check({tag, " flags"}, 32'(flags), 32'(exp));
        check({tag, " idle"}, 32'(running), 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R3: reset state
        check("R3 flags", 32'(flags), 32'd0);
        check("R3 running", 32'(running), 32'd0);
        check("R3 error", 32'(seq_error), 32'd0);

        // R1 R2 R10: length sweep, STOP clears enable bit
        for (int d = 0; d <= 12; d++) begin
            wr(0, ins(24'h0A1100 | 24'(d), C_CONT, 20'd0, 16'(d)));
            wr(1, ins(24'hABC1FF, C_STOP, 20'd0, 16'd9));
            go();
            hold("R2 length", 24'h0A1100 | 24'(d), eff(d));
            stopped("R10 stop", 24'hABC0FF);
        end

        // R5: counted loop sweep
        for (int n = 1; n <= 4; n++) begin
            wr(0, ins(24'h000011, C_LOOP, 20'(n), 16'd5));
            wr(1, ins(24'h000022, C_CONT, 20'd0, 16'd6));
            wr(2, ins(24'h000033, C_ENDL, 20'd1, 16'd5));
            wr(3, ins(24'h000044, C_STOP, 20'd0, 16'd0));
            go();
            hold("R5 loop head", 24'h000011, 5);
            for (int k = 0; k < n; k++) begin
                hold("R5 loop body", 24'h000022, 6);
                hold("R5 loop end", 24'h000033, 5);
            end
            stopped("R5 after loop", 24'h000044);
        end

        // R6: long delay sweep
        for (int di = 0; di < 3; di++) begin
            for (int n = 0; n <= 3; n++) begin
                int d;
                d = (di == 0) ? 3 : ((di == 1) ? 5 : 9);
                wr(0, ins(24'h000155, C_LDLY, 20'(n), 16'(d)));
                wr(1, ins(24'h000066, C_STOP, 20'd0, 16'd0));
                go();
                hold("R6 long delay", 24'h000155, eff(d) * ((n < 2) ? 2 : n));
                stopped("R6 after", 24'h000066);
            end
        end

        // R7: nested call/return
        wr(0, ins(24'h000071, C_JSR, 20'd4, 16'd5));
        wr(1, ins(24'h000072, C_CONT, 20'd0, 16'd5));
        wr(2, ins(24'h000073, C_STOP, 20'd0, 16'd0));
        wr(4, ins(24'h000074, C_JSR, 20'd8, 16'd5));
        wr(5, ins(24'h000075, C_RTS, 20'd0, 16'd5));
        wr(8, ins(24'h000078, C_RTS, 20'd0, 16'd7));
        go();
        hold("R7 call", 24'h000071, 5);
        hold("R7 nested call", 24'h000074, 5);
        hold("R7 inner ret", 24'h000078, 7);
        hold("R7 outer ret", 24'h000075, 5);
        hold("R7 resumed", 24'h000072, 5);
        stopped("R7 end", 24'h000073);

        // R8: branch skips addresses 1..2
        wr(0, ins(24'h000081, C_BR, 20'd3, 16'd5));
        wr(1, ins(24'h000082, C_CONT, 20'd0, 16'd5));
        wr(3, ins(24'h000083, C_CONT, 20'd0, 16'd6));
        wr(4, ins(24'h000084, C_STOP, 20'd0, 16'd0));
        go();
        hold("R8 branch", 24'h000081, 5);
        hold("R8 target", 24'h000083, 6);
        stopped("R8 end", 24'h000084);

        // R9 R4: wait latency sweep; trigger inside a running instruction ignored
        for (int di = 0; di < 3; di++) begin
            for (int k = 0; k < 2; k++) begin
                int d;
                d = (di == 0) ? 0 : ((di == 1) ? 5 : 8);
                wr(0, ins(24'h000091, C_CONT, 20'd0, 16'd5));
                wr(1, ins(24'h000192, C_WAIT, 20'd0, 16'(d)));
                wr(2, ins(24'h000093, C_STOP, 20'd0, 16'd0));
                sw_trig = 1'b1;
                @(negedge clk);
                sw_trig = 1'b0;
                hold("R4 start sw", 24'h000091, 2);
                sw_trig = 1'b1;
                hold("R4 trig ignored", 24'h000091, 1);
                sw_trig = 1'b0;
                hold("R4 full length", 24'h000091, 2);
                hold("R9 waiting", 24'h000192, 3 * k + 1);
                sw_trig = 1'b1;
                @(negedge clk);
                sw_trig = 1'b0;
                hold("R9 resume latency", 24'h000192, eff(d) + 6);
                stopped("R9 end", 24'h000093);
            end
        end

        // R12: write and fetch of the same address at one edge
        wr(0, ins(24'h0000C1, C_CONT, 20'd0, 16'd5));
        wr(1, ins(24'h0000C2, C_CONT, 20'd0, 16'd5));
        wr(2, ins(24'h0000C3, C_STOP, 20'd0, 16'd0));
        go();
        hold("R12 first", 24'h0000C1, 4);
        check("R12 before write", 32'(flags), 32'h0000C1);
        wr(1, ins(24'h0000CC, C_CONT, 20'd0, 16'd5));
        hold("R12 old word fetched", 24'h0000C2, 5);
        stopped("R12 end", 24'h0000C3);
        go();
        hold("R12 rerun", 24'h0000C1, 5);
        hold("R12 new word", 24'h0000CC, 5);
        stopped("R12 end2", 24'h0000C3);

        // R11: return stack overflow (9th call)
        wr(0, ins(24'h0001D1, C_JSR, 20'd0, 16'd5));
        go();
        hold("R11 calls", 24'h0001D1, 45);
        check("R11 ovf error", 32'(seq_error), 32'd1);
        stopped("R11 ovf", 24'h0000D1);
        go();
        @(negedge clk);
        stopped("R11 trig ignored", 24'h0000D1);
        do_reset();

        // R11: loop stack overflow (9th LOOP)
        for (int a = 0; a < 9; a++) begin
            wr(a, ins(24'h0001E1, C_LOOP, 20'd2, 16'd5));
        end
        go();
        hold("R11 loops", 24'h0001E1, 45);
        check("R11 loop ovf error", 32'(seq_error), 32'd1);
        stopped("R11 loop ovf", 24'h0000E1);
        do_reset();
        check("R3 error cleared", 32'(seq_error), 32'd0);

        // R11: underflow of each stack
        for (int u = 0; u < 2; u++) begin
            wr(0, ins(24'h0001F1, (u == 0) ? C_RTS : C_ENDL, 20'd0, 16'd6));
            go();
            hold("R11 underflow instr", 24'h0001F1, 6);
            check("R11 underflow error", 32'(seq_error), 32'd1);
            stopped("R11 underflow", 24'h0000F1);
            do_reset();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule